// File: doc/BRIEF.md
# Emulation-Mode Entry and Pin-State Controller

This block chooses how the address-latch strobe, the program-fetch strobe and four 8-bit ports are driven in each operating condition of a small microcontroller: the reset default, normal run, idle, power-down, and an in-circuit emulation mode. In emulation mode an external emulator drives the board. The controller releases the bus port fully and leaves every other pin on a weak pull-up. In idle and power-down, the pin states depend on the power mode and on whether program memory is internal or external.

Emulation mode is entered by a pin sequence at reset release. The two strobe pins are sampled as inputs through two-flop synchronizers. While the reset pin is high, the address strobe is held low and the fetch strobe is seen high; this arms entry. If the address strobe is still low when the synchronized reset falls, the controller enters emulation. An ordinary reset is the only way out of emulation.

The sequencer has four states:
- `ST_RST_PLAIN`: in reset, not armed.
- `ST_RST_ARMED`: in reset, entry condition seen.
- `ST_RUN`: running.
- `ST_EMUL`: emulation.

Its transitions are:
- **arm**: PLAIN to ARMED, when the address strobe is low and the fetch strobe is high during reset.
- **disarm**: ARMED to PLAIN, when the address strobe goes high during reset.
- **release**: PLAIN to RUN, or ARMED to RUN when the address strobe is high.
- **enter**: ARMED to EMUL, when the address strobe is low at release.
- **re-reset**: RUN or EMUL to PLAIN or ARMED, when reset rises.

While in `ST_RUN`, the output stage selects run, idle or power-down from the status inputs. Power-down has priority over idle.

Top module: `emul_pinctl`

## Requirements
- R1: While the synchronized reset pin is high, every port drives value 0xFF with output enable 1 and pull-up 1. Both strobes show value 1, output enable 0 and pull-up 1. This also holds right after `rst_n` is released.
- R2: If the address strobe is low while the fetch strobe is high during reset, and the address strobe is still low at release, the block enters emulation mode.
- R3: If the address strobe is high at release, the block enters run mode, even if it was armed earlier in the same reset.
- R4: If the address strobe is low during reset but the fetch strobe is never high at the same time, reset release leads to run mode.
- R5: In emulation, port 0 floats: value 0, output enable 0, pull-up 0. Ports 1 to 3 and both strobes show value 0xFF (or 1), output enable 0 and pull-up 1. Latches, `idle`, `pdown` and `ext_prog` have no effect on this.
- R6: Emulation persists until the reset pin rises again. After an ordinary reset the block runs normally. A reset that repeats the entry sequence returns it to emulation.
- R7: In run mode with neither `idle` nor `pdown`:
  - The strobes drive `ale_bus` and `psen_bus` with output enable 1 and pull-up 0.
  - Port 0 drives its latch with pull-up 0.
  - Ports 1 to 3 drive their latches with pull-up 1.
- R8: In idle, both strobes drive 1. In power-down, both drive 0. In both cases output enable is 1 and pull-up is 0, and `pdown` wins over `idle`.
- R9: In idle and in power-down, port 0 drives its latch (output enable 1, pull-up 0) when `ext_prog` is 0. It floats (value 0, output enable 0, pull-up 0) when `ext_prog` is 1.
- R10: In idle and in power-down, port 2 outputs `addr_hi` only when the block is in idle with `ext_prog` 1, and its latch otherwise. Ports 1 and 3 output their latches. All three have output enable 1 and pull-up 1.
- R11: A fall of the reset pin takes effect on the outputs after the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, kept running in emulation |
| rst_n | input | 1 | Asynchronous power-on reset of the block's flops, active low |
| rst_pin | input | 1 | Device reset pin level, active high, asynchronous |
| ale_in | input | 1 | Sampled level of the address-strobe pin |
| psen_in | input | 1 | Sampled level of the fetch-strobe pin |
| ale_bus | input | 1 | Address-strobe value from the bus timing logic in run mode |
| psen_bus | input | 1 | Fetch-strobe value from the bus timing logic in run mode |
| idle | input | 1 | Idle status |
| pdown | input | 1 | Power-down status |
| ext_prog | input | 1 | 1 when program memory is external |
| p0_lat | input | 8 | Port 0 latch |
| p1_lat | input | 8 | Port 1 latch |
| p2_lat | input | 8 | Port 2 latch |
| p3_lat | input | 8 | Port 3 latch |
| addr_hi | input | 8 | High address byte |
| ale_val | output | 1 | Address-strobe pin value |
| ale_oe | output | 1 | Address-strobe output enable |
| ale_pu | output | 1 | Address-strobe weak pull-up |
| psen_val | output | 1 | Fetch-strobe pin value |
| psen_oe | output | 1 | Fetch-strobe output enable |
| psen_pu | output | 1 | Fetch-strobe weak pull-up |
| p0_val | output | 8 | Port 0 value |
| p0_oe | output | 1 | Port 0 output enable |
| p0_pu | output | 1 | Port 0 weak pull-up |
| p1_val | output | 8 | Port 1 value |
| p1_oe | output | 1 | Port 1 output enable |
| p1_pu | output | 1 | Port 1 weak pull-up |
| p2_val | output | 8 | Port 2 value |
| p2_oe | output | 1 | Port 2 output enable |
| p2_pu | output | 1 | Port 2 weak pull-up |
| p3_val | output | 8 | Port 3 value |
| p3_oe | output | 1 | Port 3 output enable |
| p3_pu | output | 1 | Port 3 weak pull-up |

## Verification
The bench aims at the following corner cases:
- **Address strobe rises just before release after arming.** A sequencer that latched "armed" without rechecking the strobe at release would wrongly enter emulation here.
- **Address strobe low while the fetch strobe is low.** A design that ignored the fetch strobe would enter emulation here as well.
- **Emulation under random status and latch values.** This exposes a design that lets power-down or the latches leak through, or that leaves emulation without a reset.
- **Idle against power-down with external program memory.** Random mixes here catch a design that swaps the strobe levels, that outputs the address byte in power-down, or that drives port 0 while it should float.
- **The exact cycle of reset release.** Checking this cycle catches a synchronizer that is one stage short or too long.

// File: rtl/emul_pinctl_pkg.sv
package emul_pinctl_pkg;

    typedef enum logic [2:0] {
        PM_RESET,
        PM_RUN,
        PM_IDLE,
        PM_PDOWN,
        PM_EMUL
    } pin_mode_e;

    typedef struct packed {
        logic val;
        logic oe;
        logic pu;
    } strobe_pin_t;

endpackage

// File: rtl/emul_pinctl_sync.sv
module emul_pinctl_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/emul_pinctl_fsm.sv
module emul_pinctl_fsm
    import emul_pinctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_s,
    input  logic      ale_s,
    input  logic      psen_s,
    input  logic      idle,
    input  logic      pdown,
    output pin_mode_e mode
);
    typedef enum logic [1:0] {
        ST_RST_PLAIN,
        ST_RST_ARMED,
        ST_RUN,
        ST_EMUL
    } seq_state_e;

    seq_state_e state_q, state_d;
    logic       entry_cond;

    assign entry_cond = !ale_s && psen_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_PLAIN, ST_RST_ARMED: begin
                if (rst_s) begin
                    if (entry_cond)  state_d = ST_RST_ARMED;
                    else if (ale_s)  state_d = ST_RST_PLAIN;
                end else if (state_q == ST_RST_ARMED && !ale_s) begin
                    state_d = ST_EMUL;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN, ST_EMUL: begin
                if (rst_s) state_d = entry_cond ? ST_RST_ARMED : ST_RST_PLAIN;
            end
            default: state_d = ST_RST_PLAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST_PLAIN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RST_PLAIN, ST_RST_ARMED: mode = PM_RESET;
            ST_EMUL:                    mode = PM_EMUL;
            ST_RUN: begin
                if (pdown)     mode = PM_PDOWN;
                else if (idle) mode = PM_IDLE;
                else           mode = PM_RUN;
            end
            default:                    mode = PM_RESET;
        endcase
    end

    assert_emul_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMUL && !rst_s) |=> (state_q == ST_EMUL));

    assert_emul_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMUL && $past(state_q) != ST_EMUL)
            |-> ($past(state_q) == ST_RST_ARMED && !$past(ale_s)));

    assert_release_ale_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RST_PLAIN || state_q == ST_RST_ARMED) && !rst_s && ale_s)
            |=> (state_q == ST_RUN));

    assert_plain_no_emul_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST_PLAIN && !rst_s) |=> (state_q == ST_RUN));
endmodule

// File: rtl/emul_pinctl_drive.sv
module emul_pinctl_drive
    import emul_pinctl_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 8
) (
    input  pin_mode_e                     mode,
    input  logic                          ext_prog,
    input  logic                          ale_bus,
    input  logic                          psen_bus,
    input  logic [NPORT-1:0][PORT_W-1:0]  lat,
    input  logic [PORT_W-1:0]             addr_hi,
    output strobe_pin_t                   ale_o,
    output strobe_pin_t                   psen_o,
    output logic [NPORT-1:0][PORT_W-1:0]  pval,
    output logic [NPORT-1:0]              poe,
    output logic [NPORT-1:0]              ppu
);
    localparam int BUS_PORT  = 0;
    localparam int ADDR_PORT = 2;

    always_comb begin
        unique case (mode)
            PM_RESET, PM_EMUL: begin
                ale_o  = '{val: 1'b1, oe: 1'b0, pu: 1'b1};
                psen_o = '{val: 1'b1, oe: 1'b0, pu: 1'b1};
            end
            PM_RUN: begin
                ale_o  = '{val: ale_bus,  oe: 1'b1, pu: 1'b0};
                psen_o = '{val: psen_bus, oe: 1'b1, pu: 1'b0};
            end
            PM_IDLE: begin
                ale_o  = '{val: 1'b1, oe: 1'b1, pu: 1'b0};
                psen_o = '{val: 1'b1, oe: 1'b1, pu: 1'b0};
            end
            PM_PDOWN: begin
                ale_o  = '{val: 1'b0, oe: 1'b1, pu: 1'b0};
                psen_o = '{val: 1'b0, oe: 1'b1, pu: 1'b0};
            end
            default: begin
                ale_o  = '{val: 1'b1, oe: 1'b0, pu: 1'b1};
                psen_o = '{val: 1'b1, oe: 1'b0, pu: 1'b1};
            end
        endcase
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        localparam bit IS_BUS  = (i == BUS_PORT);
        localparam bit IS_ADDR = (i == ADDR_PORT);

        always_comb begin
            unique case (mode)
                PM_RESET: begin
                    pval[i] = '1;
                    poe[i]  = 1'b1;
                    ppu[i]  = 1'b1;
                end
                PM_EMUL: begin
                    pval[i] = IS_BUS ? '0 : '1;
                    poe[i]  = 1'b0;
                    ppu[i]  = !IS_BUS;
                end
                PM_RUN: begin
                    pval[i] = lat[i];
                    poe[i]  = 1'b1;
                    ppu[i]  = !IS_BUS;
                end
                PM_IDLE, PM_PDOWN: begin
                    if (IS_BUS) begin
                        pval[i] = ext_prog ? '0 : lat[i];
                        poe[i]  = !ext_prog;
                        ppu[i]  = 1'b0;
                    end else begin
                        pval[i] = (IS_ADDR && mode == PM_IDLE && ext_prog) ? addr_hi : lat[i];
                        poe[i]  = 1'b1;
                        ppu[i]  = 1'b1;
                    end
                end
                default: begin
                    pval[i] = '1;
                    poe[i]  = 1'b1;
                    ppu[i]  = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/emul_pinctl.sv
module emul_pinctl
    import emul_pinctl_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin,
    input  logic              ale_in,
    input  logic              psen_in,
    input  logic              ale_bus,
    input  logic              psen_bus,
    input  logic              idle,
    input  logic              pdown,
    input  logic              ext_prog,
    input  logic [PORT_W-1:0] p0_lat,
    input  logic [PORT_W-1:0] p1_lat,
    input  logic [PORT_W-1:0] p2_lat,
    input  logic [PORT_W-1:0] p3_lat,
    input  logic [PORT_W-1:0] addr_hi,
    output logic              ale_val,
    output logic              ale_oe,
    output logic              ale_pu,
    output logic              psen_val,
    output logic              psen_oe,
    output logic              psen_pu,
    output logic [PORT_W-1:0] p0_val,
    output logic              p0_oe,
    output logic              p0_pu,
    output logic [PORT_W-1:0] p1_val,
    output logic              p1_oe,
    output logic              p1_pu,
    output logic [PORT_W-1:0] p2_val,
    output logic              p2_oe,
    output logic              p2_pu,
    output logic [PORT_W-1:0] p3_val,
    output logic              p3_oe,
    output logic              p3_pu
);
    localparam int NPORT  = 4;
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0]              sync_q;
    logic                           rst_s, ale_s, psen_s;
    pin_mode_e                      mode;
    strobe_pin_t                    ale_o, psen_o;
    logic [NPORT-1:0][PORT_W-1:0]   lat, pval;
    logic [NPORT-1:0]               poe, ppu;

    emul_pinctl_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({rst_pin, ale_in, psen_in}),
        .q     (sync_q)
    );

    assign {rst_s, ale_s, psen_s} = sync_q;

    emul_pinctl_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_s  (rst_s),
        .ale_s  (ale_s),
        .psen_s (psen_s),
        .idle   (idle),
        .pdown  (pdown),
        .mode   (mode)
    );

    assign lat = {p3_lat, p2_lat, p1_lat, p0_lat};

    emul_pinctl_drive #(
        .NPORT  (NPORT),
        .PORT_W (PORT_W)
    ) u_drive (
        .mode     (mode),
        .ext_prog (ext_prog),
        .ale_bus  (ale_bus),
        .psen_bus (psen_bus),
        .lat      (lat),
        .addr_hi  (addr_hi),
        .ale_o    (ale_o),
        .psen_o   (psen_o),
        .pval     (pval),
        .poe      (poe),
        .ppu      (ppu)
    );

    assign {ale_val, ale_oe, ale_pu}    = ale_o;
    assign {psen_val, psen_oe, psen_pu} = psen_o;
    assign {p3_val, p2_val, p1_val, p0_val} = pval;
    assign {p3_oe, p2_oe, p1_oe, p0_oe}     = poe;
    assign {p3_pu, p2_pu, p1_pu, p0_pu}     = ppu;

    assert_emul_p0_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_EMUL) |-> (!p0_oe && !p0_pu && !ale_oe && !psen_oe));

    assert_pdown_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PDOWN) |-> (ale_oe && !ale_val && psen_oe && !psen_val));

    assert_reset_ports_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_s |=> (p1_oe && p1_pu && (&p1_val) && !ale_oe && ale_pu));
endmodule

// File: tb/emul_pinctl_tb_top.sv
module emul_pinctl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b1, ale_in = 1'b1, psen_in = 1'b1;
    logic ale_bus = 1'b0, psen_bus = 1'b0, idle = 1'b0, pdown = 1'b0, ext_prog = 1'b0;
    logic [7:0] p0_lat = '0, p1_lat = '0, p2_lat = '0, p3_lat = '0, addr_hi = '0;
    logic ale_val, ale_oe, ale_pu, psen_val, psen_oe, psen_pu;
    logic [7:0] p0_val, p1_val, p2_val, p3_val;
    logic p0_oe, p0_pu, p1_oe, p1_pu, p2_oe, p2_pu, p3_oe, p3_pu;

    int errs = 0;
    int checks = 0;
    bit finished = 1'b0;

    localparam int M_RESET = 0;
    localparam int M_RUN   = 1;
    localparam int M_EMUL  = 2;

    always #10 clk = ~clk;

    emul_pinctl dut_i (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ale_in(ale_in), .psen_in(psen_in),
        .ale_bus(ale_bus), .psen_bus(psen_bus), .idle(idle), .pdown(pdown), .ext_prog(ext_prog),
        .p0_lat(p0_lat), .p1_lat(p1_lat), .p2_lat(p2_lat), .p3_lat(p3_lat), .addr_hi(addr_hi),
        .ale_val(ale_val), .ale_oe(ale_oe), .ale_pu(ale_pu),
        .psen_val(psen_val), .psen_oe(psen_oe), .psen_pu(psen_pu),
        .p0_val(p0_val), .p0_oe(p0_oe), .p0_pu(p0_pu),
        .p1_val(p1_val), .p1_oe(p1_oe), .p1_pu(p1_pu),
        .p2_val(p2_val), .p2_oe(p2_oe), .p2_pu(p2_pu),
        .p3_val(p3_val), .p3_oe(p3_oe), .p3_pu(p3_pu)
    );

    function automatic logic [45:0] got_pins();
        return {ale_val, ale_oe, ale_pu, psen_val, psen_oe, psen_pu,
                p0_val, p0_oe, p0_pu, p1_val, p1_oe, p1_pu,
                p2_val, p2_oe, p2_pu, p3_val, p3_oe, p3_pu};
    endfunction

    function automatic logic [45:0] exp_pins(int m);
        logic [2:0] a, p;
        logic [9:0] q0, q1, q2, q3;
        if (m == M_RESET) begin
            a = 3'b101; p = 3'b101;
            q0 = {8'hFF, 2'b11}; q1 = q0; q2 = q0; q3 = q0;
        end else if (m == M_EMUL) begin
            a = 3'b101; p = 3'b101;
            q0 = {8'h00, 2'b00}; q1 = {8'hFF, 2'b01}; q2 = q1; q3 = q1;
        end else if (!idle && !pdown) begin
            a = {ale_bus, 2'b10}; p = {psen_bus, 2'b10};
            q0 = {p0_lat, 2'b10}; q1 = {p1_lat, 2'b11};
            q2 = {p2_lat, 2'b11}; q3 = {p3_lat, 2'b11};
        end else begin
            a = pdown ? 3'b010 : 3'b110; p = a;
            q0 = ext_prog ? {8'h00, 2'b00} : {p0_lat, 2'b10};
            q1 = {p1_lat, 2'b11};
            q2 = {(!pdown && ext_prog) ? addr_hi : p2_lat, 2'b11};
            q3 = {p3_lat, 2'b11};
        end
        return {a, p, q0, q1, q2, q3};
    endfunction

    task automatic check_pins(int m, string req);
        logic [45:0] g, e;
        #1;
        g = got_pins();
        e = exp_pins(m);
        checks++;
        if (g !== e) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, g, e);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic reset_seq(logic ale_a, logic psen_a, logic ale_rel, int m_exp, string req);
        rst_pin = 1'b1; ale_in = ale_a; psen_in = psen_a;
        tick(5);
        check_pins(M_RESET, "R1");
        ale_in = ale_rel; psen_in = 1'b1;
        tick(4);
        rst_pin = 1'b0;
        tick(2);
        check_pins(M_RESET, "R11");
        tick(1);
        check_pins(m_exp, req);
    endtask

    task automatic randomize_inputs(bit allow_lp);
        {p0_lat, p1_lat, p2_lat, p3_lat} = {$urandom, $urandom};
        addr_hi = 8'($urandom);
        ale_bus = 1'($urandom); psen_bus = 1'($urandom);
        ext_prog = 1'($urandom);
        idle = allow_lp ? 1'($urandom) : 1'b0;
        pdown = allow_lp ? 1'($urandom) : 1'b0;
        ale_in = 1'($urandom); psen_in = 1'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(3);
        check_pins(M_RESET, "R1");
        rst_n = 1'b1;
        tick(2);
        check_pins(M_RESET, "R1");

        // R2: entry sequence
        reset_seq(1'b0, 1'b1, 1'b0, M_EMUL, "R2");
        // R5: emulation ignores everything but reset
        for (int k = 0; k < 200; k++) begin
            randomize_inputs(1'b1);
            check_pins(M_EMUL, "R5");
            tick(1);
        end
        ale_in = 1'b1;
        check_pins(M_EMUL, "R6");

        // R6: ordinary reset leaves emulation
        reset_seq(1'b1, 1'b1, 1'b1, M_RUN, "R6");
        // R7 / R8 / R9 / R10: random run and low-power mixes
        for (int k = 0; k < 300; k++) begin
            randomize_inputs(k >= 60);
            check_pins(M_RUN, (idle || pdown) ? "R8_R9_R10" : "R7");
            tick(1);
        end
        // directed low-power corners
        idle = 1'b1; pdown = 1'b1; ext_prog = 1'b1;
        check_pins(M_RUN, "R8");
        idle = 1'b1; pdown = 1'b0; ext_prog = 1'b1; addr_hi = 8'hA5; p2_lat = 8'h3C;
        check_pins(M_RUN, "R10");
        idle = 1'b0; pdown = 1'b1; ext_prog = 1'b1;
        check_pins(M_RUN, "R9");
        idle = 1'b1; pdown = 1'b0; ext_prog = 1'b0; p0_lat = 8'h96;
        check_pins(M_RUN, "R9");
        idle = 1'b0; pdown = 1'b0;

        // R3: armed, then strobe high at release
        reset_seq(1'b0, 1'b1, 1'b1, M_RUN, "R3");
        // R4: strobe low but fetch strobe low throughout
        rst_pin = 1'b1; ale_in = 1'b0; psen_in = 1'b0;
        tick(6);
        check_pins(M_RESET, "R1");
        rst_pin = 1'b0;
        tick(3);
        check_pins(M_RUN, "R4");

        // R6: reset repeating the entry sequence returns to emulation
        reset_seq(1'b0, 1'b1, 1'b0, M_EMUL, "R2");
        reset_seq(1'b0, 1'b1, 1'b0, M_EMUL, "R6");
        pdown = 1'b1; idle = 1'b1;
        tick(3);
        check_pins(M_EMUL, "R6");
        pdown = 1'b0; idle = 1'b0;
        reset_seq(1'b1, 1'b0, 1'b1, M_RUN, "R6");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule